// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit turns a processor's segment-relative memory requests into 20-bit physical byte addresses and runs them on a byte-wide request/acknowledge bus. It holds four 16-bit segment base registers (code, data, stack, extra) that can be written through a dedicated write port. For a memory request, the selected base is shifted left four bits and added to the 16-bit offset. Any carry past the top of the 1 MB space is dropped.

A word access is split into two byte transactions, lower address first. Read bytes are assembled into a 16-bit little-endian result. I/O requests skip the segment logic completely: the 16-bit port number is placed on the bus zero-extended, with a flag that marks the I/O space.

The unit takes one request at a time. It reports `busy` from acceptance until a one-cycle `done` pulse that follows the last acknowledge.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset, `busy`, `done`, `bus_req` and `rdata` are 0 and all four segment registers hold 0.
- R2: A memory byte address equals (segment value × 16 + offset) with only the low 20 bits kept.
- R3: `req_seg` and `seg_wr_sel` use the same code: 0 code, 1 data, 2 stack, 3 extra. Each code reaches its own register.
- R4: A word access runs two bus transactions: first at offset, then at (offset+1) mod 2^16 in the same segment.
- R5: `rdata` is updated when `done` pulses. For a word read it is {second byte, first byte}. For a byte read it is {8'h00, byte}.
- R6: A write sends `req_wdata[7:0]` on the first transaction and `req_wdata[15:8]` on the second. `bus_we` is 1 on every transaction of a write and 0 on every transaction of a read.
- R7: For an I/O request, `bus_io` is 1 and `bus_addr` is {4'h0, port}. For an I/O word, the second port is (port+1) mod 2^16. Memory transactions carry `bus_io` = 0.
- R8: A segment write is visible from the next clock edge. A request accepted in the same cycle as the write uses the previous value.
- R9: A request is taken only while `busy` is 0. `busy` rises on the edge that accepts it and stays 1 through the single-cycle `done` pulse. Requests that arrive while busy cause no bus activity.
- R10: A segment plus offset sum of 2^20 or more wraps, so base FFFF0h plus offset 20h addresses 00010h.
- R11: While `bus_req` is 1 and not yet acknowledged, `bus_addr`, `bus_we` and `bus_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write |
| seg_wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Access request |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit, 0 = 8-bit |
| req_seg | input | 2 | Segment select for memory requests |
| req_offset | input | 16 | Offset or port number |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Assembled read data |
| bus_req | output | 1 | Byte transaction request |
| bus_io | output | 1 | Transaction targets I/O space |
| bus_we | output | 1 | Transaction is a write |
| bus_addr | output | 20 | Byte address |
| bus_wdata | output | 8 | Byte write data |
| bus_ack | input | 1 | Transaction acknowledge |
| bus_rdata | input | 8 | Byte read data |

## Verification
The checker watches every cycle for the following:
- bus request hold and stability while unacknowledged;
- the single-cycle completion pulse and its relation to `busy`;
- acceptance from idle;
- the zero upper nibble of I/O addresses;
- the state right after reset.

The address arithmetic can only be shown by the bench's directed scenarios. This covers the segment shift-and-add, offset wrap inside a segment, wrap at the top of memory, byte order and read assembly, old-versus-new segment value on a simultaneous write, and the absence of bus traffic for requests made while busy.

// File: rtl/seg_addr_pkg.sv
// Shared definitions for the segmented address generation unit.
// Assumes a byte-wide bus; word accesses are two bytes.
package seg_addr_pkg;
    localparam int BYTE_W = 8;

    // Segment select codes (shared by request and write ports)
    localparam logic [1:0] SEG_CODE  = 2'd0;
    localparam logic [1:0] SEG_DATA  = 2'd1;
    localparam logic [1:0] SEG_STACK = 2'd2;
    localparam logic [1:0] SEG_EXTRA = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_FIN  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/seg_bank.sv
// Segment base register bank: NSEG registers of SEG_W bits, one write
// port and one combinational read port. Writes land on the next edge,
// so a same-cycle read returns the old value.
module seg_bank #(
    parameter int NSEG  = 4,
    parameter int SEG_W = 16,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SEG_W-1:0] rd_val
);
    logic [SEG_W-1:0] regs_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        // Hold one segment base; cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))
                regs_q[g] <= wr_data;
        end
    end

    // Select the base for the incoming request
    always_comb rd_val = regs_q[rd_sel];
endmodule

// File: rtl/seg_addr_calc.sv
// Physical address former. Memory: (base << SHIFT) + offset, carry out
// of the top bit dropped. I/O: offset zero-extended, base ignored.
module seg_addr_calc #(
    parameter int ADDR_W = 20,
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    localparam int SHIFT = ADDR_W - SEG_W
) (
    input  logic              io,
    input  logic [SEG_W-1:0]  base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] base_ext;

    // Widen both operands and add modulo 2^ADDR_W
    always_comb begin
        off_ext  = {{(ADDR_W-OFF_W){1'b0}}, offset};
        base_ext = {base, {SHIFT{1'b0}}};
        addr     = io ? off_ext : base_ext + off_ext;
    end
endmodule

// File: rtl/seg_seq.sv
// Access sequencer: accepts one request while idle, runs one or two
// byte transactions (low address first), assembles read data and
// pulses done. Offset advances modulo 2^OFF_W for the second byte.
module seg_seq
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_io,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [SEG_W-1:0]  req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [2*BYTE_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [2*BYTE_W-1:0] rdata,
    output logic              bus_req,
    output logic              bus_io,
    output logic              bus_we,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic [SEG_W-1:0]  cur_base,
    output logic [OFF_W-1:0]  cur_off,
    input  logic              bus_ack,
    input  logic [BYTE_W-1:0] bus_rdata
);
    seq_state_e          st_q;
    logic                io_q, we_q, word_q;
    logic [SEG_W-1:0]    base_q;
    logic [OFF_W-1:0]    off_q;
    logic [2*BYTE_W-1:0] wdata_q;
    logic [BYTE_W-1:0]   lo_q;
    logic [2*BYTE_W-1:0] rdata_q;
    logic                accept;

    always_comb accept = (st_q == ST_IDLE) && req_valid;

    // State machine and captured request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            io_q    <= 1'b0;
            we_q    <= 1'b0;
            word_q  <= 1'b0;
            base_q  <= '0;
            off_q   <= '0;
            wdata_q <= '0;
            lo_q    <= '0;
            rdata_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (accept) begin
                    st_q    <= ST_LO;
                    io_q    <= req_io;
                    we_q    <= req_write;
                    word_q  <= req_word;
                    base_q  <= req_base;
                    off_q   <= req_offset;
                    wdata_q <= req_wdata;
                end
                ST_LO: if (bus_ack) begin
                    lo_q <= bus_rdata;
                    if (word_q) begin
                        st_q  <= ST_HI;
                        off_q <= off_q + 1'b1;
                    end else begin
                        st_q    <= ST_FIN;
                        rdata_q <= {{BYTE_W{1'b0}}, bus_rdata};
                    end
                end
                ST_HI: if (bus_ack) begin
                    st_q    <= ST_FIN;
                    rdata_q <= {bus_rdata, lo_q};
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Drive status and bus-side outputs from the current state
    always_comb begin
        busy      = (st_q != ST_IDLE);
        done      = (st_q == ST_FIN);
        bus_req   = (st_q == ST_LO) || (st_q == ST_HI);
        bus_io    = io_q;
        bus_we    = we_q;
        bus_wdata = (st_q == ST_HI) ? wdata_q[2*BYTE_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
        cur_base  = base_q;
        cur_off   = off_q;
        rdata     = rdata_q;
    end
endmodule

// File: rtl/seg_addr_unit.sv
// Top: segmented address generation unit. Segment bank feeds the
// sequencer at acceptance; the address former turns the captured base
// and the running offset into the 20-bit bus address.
module seg_addr_unit
    import seg_addr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int NSEG   = 4,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              req_valid,
    input  logic              req_io,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [SEL_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [15:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rdata,
    output logic              bus_req,
    output logic              bus_io,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata
);
    logic [SEG_W-1:0] sel_base;
    logic [SEG_W-1:0] cur_base;
    logic [OFF_W-1:0] cur_off;

    seg_bank #(.NSEG(NSEG), .SEG_W(SEG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .rd_sel  (req_seg),
        .rd_val  (sel_base)
    );

    seg_seq #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_io     (req_io),
        .req_write  (req_write),
        .req_word   (req_word),
        .req_base   (sel_base),
        .req_offset (req_offset),
        .req_wdata  (req_wdata),
        .busy       (busy),
        .done       (done),
        .rdata      (rdata),
        .bus_req    (bus_req),
        .bus_io     (bus_io),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .cur_base   (cur_base),
        .cur_off    (cur_off),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata)
    );

    seg_addr_calc #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .OFF_W(OFF_W)) u_calc (
        .io     (bus_io),
        .base   (cur_base),
        .offset (cur_off),
        .addr   (bus_addr)
    );
endmodule

// File: rtl/seg_addr_unit_chk.sv
// Cycle-level checker for seg_addr_unit, attached by bind below.
// Assumes synchronous active-low reset.
module seg_addr_unit_chk #(
    parameter int ADDR_W = 20,
    parameter int OFF_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              bus_req,
    input logic              bus_io,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_ack
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !bus_req)); // R1

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                                && $stable(bus_wdata)); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy && !bus_req); // R9

    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy); // R9

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_valid |=> busy && bus_req); // R9

    AST_IO_NOSEG: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_io |-> bus_addr[ADDR_W-1:OFF_W] == '0); // R7
endmodule

bind seg_addr_unit seg_addr_unit_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .bus_req   (bus_req),
    .bus_io    (bus_io),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/tb_seg_addr_unit.sv
// Directed bench for seg_addr_unit: one task per scenario.
module tb_seg_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [15:0] req_offset = '0, req_wdata = '0;
    logic        busy, done, bus_req, bus_io, bus_we;
    logic [15:0] rdata;
    logic [19:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata = '0;

    int checks = 0, failures = 0;
    bit finished = 0;

    // Transaction log filled by the bus responder
    int         log_n = 0;
    logic [19:0] log_addr [4];
    logic [7:0]  log_wd   [4];
    logic        log_we   [4];
    logic        log_io   [4];
    logic [15:0] segv [4];

    always #10 clk = ~clk; // 50 MHz

    seg_addr_unit dut (.*);

    function automatic logic [7:0] rd_fn(input logic [19:0] a);
        return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] sum;
        sum = {1'b0, s, 4'h0} + {5'h0, o};
        return sum[19:0];
    endfunction

    // Bus responder: acknowledge one cycle after a request appears
    always @(negedge clk) begin
        if (bus_req && !bus_ack) begin
            bus_ack   <= 1'b1;
            bus_rdata <= rd_fn(bus_addr);
            if (log_n < 4) begin
                log_addr[log_n] = bus_addr;
                log_wd[log_n]   = bus_wdata;
                log_we[log_n]   = bus_we;
                log_io[log_n]   = bus_io;
            end
            log_n++;
        end else begin
            bus_ack <= 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_seg(input logic [1:0] sel, input logic [15:0] v);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = v;
        @(negedge clk);
        seg_wr_en = 1'b0;
        segv[sel] = v;
    endtask

    // Launch one access and wait for done (sampled at negedge)
    task automatic access(input logic io, input logic we, input logic wd,
                          input logic [1:0] sg, input logic [15:0] off, input logic [15:0] wdat);
        int n = 0;
        @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_io = io; req_write = we; req_word = wd;
        req_seg = sg; req_offset = off; req_wdata = wdat;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 bus_req", 32'(bus_req), 0);
        check("R1 rdata", 32'(rdata), 0);
        access(0, 0, 0, 2'd3, 16'h1234, 0);
        check("R1 segment zero addr", 32'(log_addr[0]), 32'h01234);
    endtask

    task automatic t_each_segment();
        wr_seg(2'd0, 16'h1000);
        wr_seg(2'd1, 16'h2345);
        wr_seg(2'd2, 16'hABCD);
        wr_seg(2'd3, 16'hFFFF);
        for (int s = 0; s < 3; s++) begin
            access(0, 0, 0, 2'(s), 16'h0019, 0);
            check("R2 R3 byte addr", 32'(log_addr[0]), 32'(phys(segv[s], 16'h0019)));
            check("R5 byte rdata", 32'(rdata), 32'({8'h00, rd_fn(phys(segv[s], 16'h0019))}));
            check("R7 mem io flag", 32'(log_io[0]), 0);
            check("R2 one transaction", log_n, 1);
        end
    endtask

    task automatic t_word_read();
        logic [19:0] a0, a1;
        a0 = phys(segv[1], 16'h0101);
        a1 = phys(segv[1], 16'h0102);
        access(0, 0, 1, 2'd1, 16'h0101, 0);
        check("R4 two transactions", log_n, 2);
        check("R4 low addr", 32'(log_addr[0]), 32'(a0));
        check("R4 high addr", 32'(log_addr[1]), 32'(a1));
        check("R5 word rdata", 32'(rdata), 32'({rd_fn(a1), rd_fn(a0)}));
        check("R6 read we", 32'({log_we[0], log_we[1]}), 0);
    endtask

    task automatic t_word_write_wrap();
        access(0, 1, 1, 2'd2, 16'hFFFF, 16'hBEEF);
        check("R4 wrap low", 32'(log_addr[0]), 32'h0BBCCF);
        check("R4 wrap high", 32'(log_addr[1]), 32'h0ABCD0);
        check("R6 low byte", 32'(log_wd[0]), 32'hEF);
        check("R6 high byte", 32'(log_wd[1]), 32'hBE);
        check("R6 write we", 32'({log_we[0], log_we[1]}), 3);
    endtask

    task automatic t_top_wrap();
        access(0, 0, 0, 2'd3, 16'h0020, 0);
        check("R10 top wrap", 32'(log_addr[0]), 32'h00010);
    endtask

    task automatic t_io();
        access(1, 0, 1, 2'd2, 16'hFFFF, 0);
        check("R7 io low", 32'(log_addr[0]), 32'h0FFFF);
        check("R7 io high", 32'(log_addr[1]), 32'h00000);
        check("R7 io flag", 32'({log_io[0], log_io[1]}), 3);
        check("R7 io rdata", 32'(rdata), 32'({rd_fn(20'h0), rd_fn(20'h0FFFF)}));
        access(1, 1, 0, 2'd1, 16'h0060, 16'h00A5);
        check("R7 io byte addr", 32'(log_addr[0]), 32'h00060);
        check("R7 io byte data", 32'(log_wd[0]), 32'hA5);
        check("R7 io byte count", log_n, 1);
    endtask

    task automatic t_same_cycle_write();
        logic [15:0] oldv;
        oldv = segv[1];
        @(negedge clk);
        log_n = 0;
        seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_data = 16'h0777;
        req_valid = 1'b1; req_io = 0; req_write = 0; req_word = 0;
        req_seg = 2'd1; req_offset = 16'h0004;
        @(negedge clk);
        seg_wr_en = 1'b0; req_valid = 1'b0;
        segv[1] = 16'h0777;
        repeat (6) @(negedge clk);
        check("R8 old value used", 32'(log_addr[0]), 32'(phys(oldv, 16'h0004)));
        access(0, 0, 0, 2'd1, 16'h0004, 0);
        check("R8 new value next", 32'(log_addr[0]), 32'h07774);
    endtask

    task automatic t_busy();
        int n = 0;
        @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_io = 0; req_write = 0; req_word = 1;
        req_seg = 2'd0; req_offset = 16'h0200;
        @(negedge clk);
        check("R9 busy after accept", 32'(busy), 1);
        req_io = 1; req_word = 0; req_offset = 16'h0099; // ignored request
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
        end
        check("R9 busy at done", 32'(busy), 1);
        @(negedge clk);
        check("R9 done one cycle", 32'(done), 0);
        check("R9 idle after done", 32'(busy), 0);
        repeat (4) @(negedge clk);
        check("R9 no extra traffic", log_n, 2);
        check("R9 first addr kept", 32'(log_addr[0]), 32'h10200);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_each_segment();
        t_word_read();
        t_word_write_wrap();
        t_top_wrap();
        t_io();
        t_same_cycle_write();
        t_busy();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule